// File: doc/BRIEF.md
# Linked List Key Search Engine

This block searches a singly linked list held in a word-addressed memory. Each node begins with a link word at offset zero that holds the address of the next node. A key word sits at a caller-chosen offset from the start of the node. After a start pulse, the engine chases links from a start pointer. At each node it compares the key against an argument. It stops at the first node that satisfies the selected test, or at the end of the list, or when it meets a corrupt link.

Two compare modes exist. One looks for a key that equals the argument. The other looks for the first key that is greater than the argument, compared as unsigned values. The result is a two-bit outcome code and two pointers: the node where the walk stopped, and the node visited just before it. The caller can use the trailing pointer to splice the list, although that work is outside this block.

The memory port is a plain synchronous read port: an address and an enable in one cycle, and the data back on the next cycle.

Top module: `list_key_search`

## Requirements
- R1: Bit 15 of `head_ptr` is cleared before the walk begins, so a start pointer with that bit set behaves exactly like the same pointer with the bit cleared.
- R2: If the start pointer is zero after bit 15 is cleared, the engine makes no memory read and finishes with outcome 1. In that case `node_ptr` is 0 and `trail_ptr` equals `prev_ptr`.
- R3: The key of the node at address N is read from memory address (N + `key_ofs`) modulo 2^15.
- R4: With `gt_mode` = 0, the walk stops at the first node whose key equals `arg_word`. It returns outcome 2 (found), `node_ptr` set to that node, and `trail_ptr` set to the node visited before it, or to `prev_ptr` if no node was visited before it.
- R5: With `gt_mode` = 1, the walk stops at the first node whose key is greater than `arg_word`, with both compared as unsigned 16-bit values. It returns outcome 2, with the pointers as in R4.
- R6: When a node does not stop the walk, the trailing pointer takes that node's address. The current pointer takes the link word read from the node's own address (offset 0).
- R7: When a link word of zero is read, the walk ends with outcome 1 (not found). `node_ptr` is 0 and `trail_ptr` is the last node visited.
- R8: When a link word with bit 15 set is read, the walk ends with outcome 0 (bad link). `node_ptr` is that link word and `trail_ptr` is the last node visited.
- R9: `done` is a single-cycle pulse, and the outcome code 3 is never produced. Count clock edges starting with the edge that samples `start`. A zero start pointer gives `done` after 1 edge. A walk that stops on the k-th visited node (k from 0) gives `done` after 3k+3 edges. A walk that ends on a link word after n nodes gives `done` after 3n+1 edges. `done`, `outcome`, `node_ptr` and `trail_ptr` are zero after reset.
- R10: A `start` pulse that arrives while a walk is in progress is ignored. The running walk's results and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| arg_word | input | 16 | Argument compared with each key |
| key_ofs | input | 16 | Offset of the key word within a node |
| head_ptr | input | 16 | Start pointer |
| prev_ptr | input | 16 | Initial trailing pointer |
| gt_mode | input | 1 | 0: equality search, 1: unsigned greater-than search |
| mem_rd_en | output | 1 | Memory read enable |
| mem_addr | output | 15 | Memory read address |
| mem_rd_data | input | 16 | Read data, valid one cycle after the enable |
| done | output | 1 | One-cycle completion pulse |
| outcome | output | 2 | 0 bad link, 1 not found, 2 found |
| node_ptr | output | 16 | Node where the walk stopped (or the terminator) |
| trail_ptr | output | 16 | Node visited before `node_ptr` |

## Verification
A behavioural model in the bench walks the same list and predicts the outcome, both pointers and the completion edge. The completion edge is 1 for an empty start pointer, 3k+3 for a stop on node k, and 3n+1 for a stop on a link word after n nodes. On every clock between the start pulse and the predicted edge, the bench samples `done` at the falling edge and requires it to be low. It requires `done` high exactly at the predicted edge and low again one edge later. Results are compared only in the cycle where `done` is high. The bench also counts memory reads to confirm that an empty start pointer makes none.

// File: rtl/lks_pkg.sv
package lks_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_KEY  = 2'd1,
    ST_CMP  = 2'd2,
    ST_LINK = 2'd3
  } walk_state_e;

  localparam logic [1:0] RES_BAD_LINK = 2'd0;
  localparam logic [1:0] RES_MISS     = 2'd1;
  localparam logic [1:0] RES_HIT      = 2'd2;
endpackage

// File: rtl/lks_addr_gen.sv
module lks_addr_gen #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = WORD_W - 1
) (
  input  logic [WORD_W-1:0] node,
  input  logic [WORD_W-1:0] offset,
  input  logic              sel_link,
  output logic [ADDR_W-1:0] addr
);
  // Link word sits at the node address; key word at node + offset, wrapped.
  assign addr = ADDR_W'(sel_link ? node : node + offset);
endmodule

// File: rtl/lks_key_cmp.sv
module lks_key_cmp #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] key,
  input  logic [WORD_W-1:0] arg,
  input  logic              gt_mode,
  output logic              stop
);
  assign stop = gt_mode ? (key > arg) : (key == arg);
endmodule

// File: rtl/list_key_search.sv
module list_key_search #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] arg_word,
  input  logic [WORD_W-1:0] key_ofs,
  input  logic [WORD_W-1:0] head_ptr,
  input  logic [WORD_W-1:0] prev_ptr,
  input  logic              gt_mode,
  output logic              mem_rd_en,
  output logic [WORD_W-2:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              done,
  output logic [1:0]        outcome,
  output logic [WORD_W-1:0] node_ptr,
  output logic [WORD_W-1:0] trail_ptr
);
  import lks_pkg::*;

  localparam int ADDR_W = WORD_W - 1;
  localparam logic [WORD_W-1:0] SIGN_MASK = {1'b1, {(WORD_W-1){1'b0}}};

  walk_state_e       st_q;
  logic [WORD_W-1:0] cur_q, trail_q, arg_q, ofs_q;
  logic              mode_q, done_q;
  logic [1:0]        res_q;
  logic              key_stop, sel_link, idle;
  logic [WORD_W-1:0] head_clean;

  assign idle       = (st_q == ST_IDLE);
  assign head_clean = head_ptr & ~SIGN_MASK;
  assign sel_link   = (st_q == ST_CMP);
  assign mem_rd_en  = (st_q == ST_KEY) || ((st_q == ST_CMP) && !key_stop);

  lks_addr_gen #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_addr (
    .node     (cur_q),
    .offset   (ofs_q),
    .sel_link (sel_link),
    .addr     (mem_addr)
  );

  lks_key_cmp #(.WORD_W(WORD_W)) u_cmp (
    .key     (mem_rd_data),
    .arg     (arg_q),
    .gt_mode (mode_q),
    .stop    (key_stop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      trail_q <= '0;
      arg_q   <= '0;
      ofs_q   <= '0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= RES_BAD_LINK;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            cur_q   <= head_clean;
            trail_q <= prev_ptr;
            arg_q   <= arg_word;
            ofs_q   <= key_ofs;
            mode_q  <= gt_mode;
            if (head_clean == '0) begin
              done_q <= 1'b1;
              res_q  <= RES_MISS;
            end else begin
              st_q <= ST_KEY;
            end
          end
        end
        ST_KEY: st_q <= ST_CMP;
        ST_CMP: begin
          if (key_stop) begin
            done_q <= 1'b1;
            res_q  <= RES_HIT;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_LINK;
          end
        end
        ST_LINK: begin
          trail_q <= cur_q;
          cur_q   <= mem_rd_data;
          if (mem_rd_data == '0) begin
            done_q <= 1'b1;
            res_q  <= RES_MISS;
            st_q   <= ST_IDLE;
          end else if ((mem_rd_data & SIGN_MASK) != '0) begin
            done_q <= 1'b1;
            res_q  <= RES_BAD_LINK;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_KEY;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign outcome   = res_q;
  assign node_ptr  = cur_q;
  assign trail_ptr = trail_q;
endmodule

// File: rtl/lks_checker.sv
module lks_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              idle,
  input logic [WORD_W-1:0] head_ptr,
  input logic              mem_rd_en,
  input logic              done,
  input logic [1:0]        outcome,
  input logic [WORD_W-1:0] node_ptr
);
  a_r2_empty_no_read: assert property (@(posedge clk) disable iff (rst)
    (idle && start && head_ptr[WORD_W-2:0] == '0) |=> (done && outcome == 2'd1 && !mem_rd_en));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_code_legal: assert property (@(posedge clk) disable iff (rst)
    done |-> (outcome != 2'd3));

  a_r7_miss_null: assert property (@(posedge clk) disable iff (rst)
    (done && outcome == 2'd1) |-> (node_ptr == '0));

  a_r8_bad_sign: assert property (@(posedge clk) disable iff (rst)
    (done && outcome == 2'd0) |-> node_ptr[WORD_W-1]);

  a_r4_hit_clean: assert property (@(posedge clk) disable iff (rst)
    (done && outcome == 2'd2) |-> (node_ptr != '0 && !node_ptr[WORD_W-1]));

  a_r10_no_read_idle: assert property (@(posedge clk) disable iff (rst)
    idle |-> !mem_rd_en);
endmodule

bind list_key_search lks_checker #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .idle      (idle),
  .head_ptr  (head_ptr),
  .mem_rd_en (mem_rd_en),
  .done      (done),
  .outcome   (outcome),
  .node_ptr  (node_ptr)
);

// File: tb/list_key_search_bench.sv
`timescale 1ns/1ps
module list_key_search_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] arg_word = '0, key_ofs = '0, head_ptr = '0, prev_ptr = '0;
  logic        gt_mode = 1'b0;
  logic        mem_rd_en;
  logic [14:0] mem_addr;
  logic [15:0] mem_rd_data = '0;
  logic        done;
  logic [1:0]  outcome;
  logic [15:0] node_ptr, trail_ptr;

  int checks = 0;
  int fails  = 0;
  int rd_count = 0;
  bit finished = 1'b0;
  logic [15:0] mem [int];

  always #2 clk = ~clk;

  list_key_search u_list_key_search (
    .clk(clk), .rst(rst), .start(start), .arg_word(arg_word), .key_ofs(key_ofs),
    .head_ptr(head_ptr), .prev_ptr(prev_ptr), .gt_mode(gt_mode),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .done(done), .outcome(outcome), .node_ptr(node_ptr), .trail_ptr(trail_ptr)
  );

  function automatic logic [15:0] rd(input logic [15:0] a);
    int idx = int'(a & 16'h7FFF);
    return mem.exists(idx) ? mem[idx] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= rd({1'b0, mem_addr});
      rd_count <= rd_count + 1;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic node(input logic [15:0] a, input logic [15:0] link, input logic [15:0] ofs, input logic [15:0] key);
    mem[int'(a)] = link;
    mem[int'((a + ofs) & 16'h7FFF)] = key;
  endtask

  // Behavioural walk: expected outcome, pointers and completion edge.
  task automatic run_case(input string req, input logic [15:0] h, input logic [15:0] p,
                          input logic [15:0] arg, input logic [15:0] ofs, input logic m,
                          input bit poke);
    logic [15:0] ea, eb, key, lnk;
    logic [1:0]  eo;
    int lat, rd0;
    bit seen;
    ea = h & 16'h7FFF; eb = p; lat = 1; eo = 2'd1;
    if (ea != 0) begin
      forever begin
        key = rd((ea + ofs) & 16'h7FFF);
        lat += 2;
        if (m ? (key > arg) : (key == arg)) begin eo = 2'd2; break; end
        lnk = rd(ea);
        lat += 1;
        eb = ea; ea = lnk;
        if (ea == 0) begin eo = 2'd1; break; end
        if (ea[15]) begin eo = 2'd0; break; end
      end
    end
    @(negedge clk);
    head_ptr = h; prev_ptr = p; arg_word = arg; key_ofs = ofs; gt_mode = m; start = 1'b1;
    rd0 = rd_count;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int c = 1; c <= lat; c++) begin
      if (poke && c == 2) begin
        head_ptr = 16'h0400; arg_word = 16'hFFFF; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (c == lat) begin
        check(req, "done at predicted edge", done, 1'b1);
        check(req, "outcome", outcome, eo);
        check(req, "node_ptr", node_ptr, ea);
        check(req, "trail_ptr", trail_ptr, eb);
        seen = 1'b1;
      end else if (done !== 1'b0) begin
        check(req, "done early", done, 1'b0);
      end
      if (c != lat) @(negedge clk);
    end
    start = 1'b0;
    if (h[14:0] == 0) check("R2", "memory reads", rd_count - rd0, 0);
    @(negedge clk);
    check("R9", "done is a single pulse", done, 1'b0);
    if (!seen) check(req, "completion seen", 0, 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9", "reset done", done, 1'b0);
    check("R9", "reset outcome", outcome, 2'd0);
    check("R9", "reset node_ptr", node_ptr, 16'h0);
    check("R9", "reset trail_ptr", trail_ptr, 16'h0);

    // List 0x100 -> 0x200 -> 0x300 -> null, keys at offset 3.
    node(16'h0100, 16'h0200, 16'h3, 16'd10);
    node(16'h0200, 16'h0300, 16'h3, 16'd20);
    node(16'h0300, 16'h0000, 16'h3, 16'h9000);
    // Corrupt list 0x400 -> 0x500 -> bad link.
    node(16'h0400, 16'h0500, 16'h3, 16'd1);
    node(16'h0500, 16'h8123, 16'h3, 16'd2);
    // Node near top of memory whose key address wraps.
    node(16'h7FF0, 16'h0000, 16'h0020, 16'h0055);

    run_case("R2", 16'h8000, 16'h1234, 16'd5, 16'h3, 1'b0, 1'b0);
    run_case("R4", 16'h0100, 16'h0777, 16'd20, 16'h3, 1'b0, 1'b0);
    run_case("R6", 16'h0100, 16'h0777, 16'h9000, 16'h3, 1'b0, 1'b0);
    run_case("R7", 16'h0100, 16'h0777, 16'd25, 16'h3, 1'b0, 1'b0);
    run_case("R5", 16'h0100, 16'h0000, 16'd15, 16'h3, 1'b1, 1'b0);
    run_case("R5", 16'h0100, 16'h0000, 16'h7000, 16'h3, 1'b1, 1'b0);
    run_case("R1", 16'h8100, 16'h0042, 16'd10, 16'h3, 1'b0, 1'b0);
    run_case("R8", 16'h0400, 16'h0000, 16'd99, 16'h3, 1'b0, 1'b0);
    run_case("R3", 16'h7FF0, 16'h0011, 16'h0055, 16'h0020, 1'b0, 1'b0);
    run_case("R10", 16'h0100, 16'h0777, 16'd20, 16'h3, 1'b0, 1'b1);
    run_case("R7", 16'h0100, 16'h0777, 16'hFFFF, 16'h3, 1'b1, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule